// File: doc/BRIEF.md
# Dual-Layout Data-Space Decoder with External SRAM Sequencer

The block takes a byte access request from a processor core, which is a 16-bit data-space address plus a read or write direction. It classifies the address into one of five regions: register file, standard I/O, extended I/O, internal SRAM or external SRAM. The `compatMode` input chooses between two address layouts. The compatible layout has no extended I/O window and a smaller internal SRAM. External SRAM then fills the rest of the 64 KiB space.

A request that lands in an internal region completes one cycle after it is issued, and the external strobes stay low. When external memory is enabled, a request for external SRAM raises exactly one strobe, read or write. The strobe is held for the programmed number of wait states plus one cycle and is released one clock before `done`. When external memory is disabled, an address beyond internal SRAM is flagged as out of range and completes like an internal access. A request can also come through the short I/O port path. That path carries a 6-bit port number and can only reach the standard I/O window.

Top module: `memDecoder`

## Requirements
- R1: With `compatMode`=0, the region reported with `done` follows this map: 0x0000–0x001F register file (code 0), 0x0020–0x005F standard I/O (code 1), 0x0060–0x00FF extended I/O (code 2), 0x0100–0x10FF internal SRAM (code 3), and 0x1100–0xFFFF external SRAM (code 4).
- R2: With `compatMode`=1, no extended I/O region exists. The map is 0x0000–0x001F register file (0), 0x0020–0x005F standard I/O (1), 0x0060–0x0FFF internal SRAM (3), and 0x1000–0xFFFF external SRAM (4).
- R3: When `reqIoPort`=1, the access targets address 0x20 plus `reqAddr[5:0]` and ignores the upper address bits. Such an access always reports region 1.
- R4: An access to any internal region pulses `done` in the cycle after the request is accepted. `extRd` and `extWr` stay low throughout, and `rdata` is 0x00.
- R5: When external memory is enabled, an external SRAM access holds its strobe for `waitSel`+1 cycles, starting in the cycle after acceptance. `done` pulses in the cycle right after the strobe drops, so the access takes 1, 2, 3 or 4 extra clocks over an internal access for `waitSel` 0, 1, 2 or 3.
- R6: At most one strobe is high at any time, and it is `extWr` for a write and `extRd` for a read. While the strobe is high, `extAddr` holds the access address and, for a write, `extWdata` holds the write data.
- R7: For an external read, `rdata` shows the `extRdata` value present in the last strobe cycle, and it is valid while `done` is high.
- R8: When `extEnable`=0 and the address lies beyond internal SRAM, no strobe fires and `done` pulses the next cycle. `rdata` is 0x00, `oorFlag` is high for that one `done` cycle, and the reported region is 4.
- R9: `waitSel` is sampled when an access is accepted. A change made during an external access does not alter that access's strobe length.
- R10: `ready` is low while an external strobe is active. A request presented then is ignored: it leaves `extAddr` unchanged and produces no later `done` or strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| compatMode | input | 1 | 1 selects the compatible layout |
| extEnable | input | 1 | Enables external SRAM operation |
| waitSel | input | 2 | Wait states for external accesses (0–3) |
| reqValid | input | 1 | Access request, accepted when `ready` is high |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqIoPort | input | 1 | Request comes through the short I/O port path |
| reqAddr | input | 16 | Data-space address, or port number in bits 5:0 |
| reqWdata | input | 8 | Write data |
| extRdata | input | 8 | Read data from external SRAM |
| ready | output | 1 | Block can accept a request |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Read data, valid with `done` |
| regionOut | output | 3 | Region code of the completed access |
| oorFlag | output | 1 | Out-of-range completion, valid with `done` |
| extAddr | output | 16 | External SRAM address |
| extWdata | output | 8 | External SRAM write data |
| extRd | output | 1 | External read strobe, active high |
| extWr | output | 1 | External write strobe, active high |

## Verification
A bad latched wait count or a stuck control state shows at the ports within one access. The strobe is then too long or too short, or `done` comes early, late or not at all, and the per-cycle comparison catches this in the first wrong cycle. A wrong boundary constant, or a missing dependence on the layout, shows up only at the `done` of an access near that boundary. For that reason every region edge in both layouts is probed on both sides. A failure to latch the address, or to ignore a request made while busy, changes `extAddr` during the strobe, or produces a stray `done` one cycle after the real one.

// File: rtl/memDecPkg.sv
package memDecPkg;
  typedef enum logic [2:0] {
    RG_REGF  = 3'd0,
    RG_STDIO = 3'd1,
    RG_EXTIO = 3'd2,
    RG_ISRAM = 3'd3,
    RG_XSRAM = 3'd4
  } regionT;

  typedef struct packed {
    logic loadReq;
    logic captureRd;
    logic strobeOn;
  } dpCtrlT;
endpackage

// File: rtl/addrDecode.sv
module addrDecode
  import memDecPkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int REGF_SZ     = 32,
  parameter int IO_SZ       = 64,
  parameter int XIO_SZ      = 160,
  parameter int SRAM_NORM   = 4096,
  parameter int SRAM_COMPAT = 4000
) (
  input  logic              compatMode,
  input  logic              ioPath,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] effAddr,
  output regionT            region
);
  localparam int IO_IDX_W   = $clog2(IO_SZ);
  localparam int IO_BASE    = REGF_SZ;
  localparam int XIO_BASE   = IO_BASE + IO_SZ;
  localparam int SRAM_BASE_N = XIO_BASE + XIO_SZ;
  localparam int EXT_BASE_N  = SRAM_BASE_N + SRAM_NORM;
  localparam int EXT_BASE_C  = XIO_BASE + SRAM_COMPAT;

  always_comb begin
    if (ioPath) effAddr = ADDR_W'(IO_BASE) + ADDR_W'(addrIn[IO_IDX_W-1:0]);
    else        effAddr = addrIn;
  end

  always_comb begin
    if (int'(effAddr) < IO_BASE)                           region = RG_REGF;
    else if (int'(effAddr) < XIO_BASE)                     region = RG_STDIO;
    else if (!compatMode && int'(effAddr) < SRAM_BASE_N)   region = RG_EXTIO;
    else if (!compatMode && int'(effAddr) < EXT_BASE_N)    region = RG_ISRAM;
    else if (compatMode && int'(effAddr) < EXT_BASE_C)     region = RG_ISRAM;
    else                                                   region = RG_XSRAM;
  end

  always_comb begin
    if (ioPath) assert (region == RG_STDIO) else $error("p_io_path_r3");
  end
endmodule

// File: rtl/accessCtrl.sv
module accessCtrl
  import memDecPkg::*;
#(
  parameter int WAIT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              extHit,
  input  logic              extEnable,
  input  logic [WAIT_W-1:0] waitSel,
  output logic              ready,
  output logic              extRd,
  output logic              extWr,
  output logic              done,
  output logic              oorFlag,
  output dpCtrlT            dpCtrl
);
  typedef enum logic {ST_IDLE, ST_STROBE} stateT;
  stateT             state;
  logic [WAIT_W-1:0] waitCnt;
  logic              isWrR;
  logic              accept;
  logic              goExt;

  assign accept = (state == ST_IDLE) && reqValid;
  assign goExt  = extHit && extEnable;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
      isWrR   <= 1'b0;
      done    <= 1'b0;
      oorFlag <= 1'b0;
    end else begin
      done    <= 1'b0;
      oorFlag <= 1'b0;
      case (state)
        ST_IDLE: if (reqValid) begin
          isWrR <= reqWrite;
          if (goExt) begin
            state   <= ST_STROBE;
            waitCnt <= waitSel;
          end else begin
            done    <= 1'b1;
            oorFlag <= extHit;
          end
        end
        ST_STROBE: begin
          if (waitCnt == '0) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            waitCnt <= waitCnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign ready = (state == ST_IDLE);
  assign extRd = (state == ST_STROBE) && !isWrR;
  assign extWr = (state == ST_STROBE) && isWrR;

  assign dpCtrl.loadReq   = accept;
  assign dpCtrl.captureRd = (state == ST_STROBE) && (waitCnt == '0) && !isWrR;
  assign dpCtrl.strobeOn  = (state == ST_STROBE);

  p_single_strobe_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(extRd && extWr));
  p_release_done_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(extRd || extWr) |-> done);
  p_done_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !(extRd || extWr));
  p_oor_with_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    oorFlag |-> (done && $past(accept)));
  p_busy_no_accept_r10: assert property (@(posedge clk) disable iff (!rstN)
    (extRd || extWr) |-> !dpCtrl.loadReq);
endmodule

// File: rtl/accessDatapath.sv
module accessDatapath
  import memDecPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrlT            dpCtrl,
  input  logic [ADDR_W-1:0] effAddr,
  input  regionT            region,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] extRdata,
  output logic [ADDR_W-1:0] extAddr,
  output logic [DATA_W-1:0] extWdata,
  output logic [DATA_W-1:0] rdata,
  output logic [2:0]        regionOut
);
  regionT regionR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extAddr  <= '0;
      extWdata <= '0;
      rdata    <= '0;
      regionR  <= RG_REGF;
    end else begin
      if (dpCtrl.loadReq) begin
        extAddr  <= effAddr;
        extWdata <= reqWdata;
        regionR  <= region;
        rdata    <= '0;
      end else if (dpCtrl.captureRd) begin
        rdata <= extRdata;
      end
    end
  end

  assign regionOut = regionR;

  p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (dpCtrl.strobeOn && $past(dpCtrl.strobeOn)) |-> ($stable(extAddr) && $stable(extWdata)));
  p_strobe_ext_region_r5: assert property (@(posedge clk) disable iff (!rstN)
    dpCtrl.strobeOn |-> (regionR == RG_XSRAM));
endmodule

// File: rtl/memDecoder.sv
module memDecoder
  import memDecPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int WAIT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              compatMode,
  input  logic              extEnable,
  input  logic [WAIT_W-1:0] waitSel,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqIoPort,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] extRdata,
  output logic              ready,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic [2:0]        regionOut,
  output logic              oorFlag,
  output logic [ADDR_W-1:0] extAddr,
  output logic [DATA_W-1:0] extWdata,
  output logic              extRd,
  output logic              extWr
);
  logic [ADDR_W-1:0] effAddr;
  regionT            region;
  dpCtrlT            dpCtrl;

  addrDecode #(.ADDR_W(ADDR_W)) u_decode (
    .compatMode(compatMode), .ioPath(reqIoPort), .addrIn(reqAddr),
    .effAddr(effAddr), .region(region)
  );

  accessCtrl #(.WAIT_W(WAIT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .extHit(region == RG_XSRAM), .extEnable(extEnable), .waitSel(waitSel),
    .ready(ready), .extRd(extRd), .extWr(extWr), .done(done),
    .oorFlag(oorFlag), .dpCtrl(dpCtrl)
  );

  accessDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .dpCtrl(dpCtrl), .effAddr(effAddr),
    .region(region), .reqWdata(reqWdata), .extRdata(extRdata),
    .extAddr(extAddr), .extWdata(extWdata), .rdata(rdata),
    .regionOut(regionOut)
  );
endmodule

// File: tb/test_memDecoder.sv
module test_memDecoder;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic compatMode = 1'b0, extEnable = 1'b1;
  logic [1:0] waitSel = 2'd0;
  logic reqValid = 1'b0, reqWrite = 1'b0, reqIoPort = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [7:0] reqWdata = '0, extRdata = '0;
  logic ready, done, oorFlag, extRd, extWr;
  logic [7:0] rdata, extWdata;
  logic [2:0] regionOut;
  logic [15:0] extAddr;

  int nChecks = 0, nBad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  memDecoder i_memDecoder (
    .clk(clk), .rstN(rstN), .compatMode(compatMode), .extEnable(extEnable),
    .waitSel(waitSel), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqIoPort(reqIoPort), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .extRdata(extRdata), .ready(ready), .done(done), .rdata(rdata),
    .regionOut(regionOut), .oorFlag(oorFlag), .extAddr(extAddr),
    .extWdata(extWdata), .extRd(extRd), .extWr(extWr)
  );

  task automatic check(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int refRegion(int a, bit cm);
    if (a < 32) return 0;
    if (a < 96) return 1;
    if (!cm) begin
      if (a < 256) return 2;
      if (a < 256 + 4096) return 3;
      return 4;
    end
    if (a < 96 + 4000) return 3;
    return 4;
  endfunction

  task automatic access(bit wr, bit io, logic [15:0] a, logic [7:0] wd,
                        logic [1:0] w, bit disturb, string tag);
    int eff, reg_, lat;
    bit ext, oor;
    logic [7:0] rdv;
    eff  = io ? 32 + int'(a[5:0]) : int'(a);
    reg_ = refRegion(eff, compatMode);
    ext  = (reg_ == 4) && extEnable;
    oor  = (reg_ == 4) && !extEnable;
    lat  = ext ? int'(w) + 2 : 1;
    rdv  = 8'hA5 ^ a[7:0] ^ {6'd0, w};
    @(negedge clk);
    check({tag, " ready idle R10"}, int'(ready), 1);
    reqValid = 1'b1; reqWrite = wr; reqIoPort = io; reqAddr = a;
    reqWdata = wd; waitSel = w; extRdata = rdv;
    for (int k = 1; k <= lat; k++) begin
      @(negedge clk);
      check({tag, " rd strobe R5"}, int'(extRd), int'(ext && !wr && k <= int'(w) + 1));
      check({tag, " wr strobe R6"}, int'(extWr), int'(ext && wr && k <= int'(w) + 1));
      check({tag, " done timing R4/R5"}, int'(done), int'(k == lat));
      check({tag, " ready busy R10"}, int'(ready), int'(!(ext && k <= int'(w) + 1)));
      if (ext && k <= int'(w) + 1) begin
        check({tag, " ext address R6"}, int'(extAddr), eff);
        if (wr) check({tag, " ext wdata R6"}, int'(extWdata), int'(wd));
      end
      if (k == lat) begin
        check({tag, " region R1/R2/R3"}, int'(regionOut), reg_);
        check({tag, " oor flag R8"}, int'(oorFlag), int'(oor));
        check({tag, " read data R7"}, int'(rdata), (ext && !wr) ? int'(rdv) : 0);
      end else begin
        check({tag, " oor idle R8"}, int'(oorFlag), 0);
      end
      if (k == 1 && disturb) begin
        waitSel = ~w;
        reqAddr = ~a;
        reqWrite = ~wr;
      end else begin
        reqValid = 1'b0;
      end
    end
    reqValid = 1'b0;
    @(negedge clk);
    check({tag, " no stray done R10"}, int'(done), 0);
    check({tag, " no stray strobe R10"}, int'(extRd || extWr), 0);
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    if (!finished) begin
      nChecks++; nBad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("reset done R4", int'(done), 0);
    check("reset strobes R6", int'(extRd || extWr), 0);
    check("reset oor R8", int'(oorFlag), 0);
    rstN = 1'b1;
    check("reset ready R10", int'(ready), 1);

    // R1 normal layout, every boundary
    access(0, 0, 16'h0000, 8'h00, 2'd0, 0, "n_0000 R1");
    access(0, 0, 16'h001F, 8'h00, 2'd0, 0, "n_001F R1");
    access(1, 0, 16'h0020, 8'h11, 2'd0, 0, "n_0020 R1");
    access(0, 0, 16'h005F, 8'h00, 2'd0, 0, "n_005F R1");
    access(0, 0, 16'h0060, 8'h00, 2'd0, 0, "n_0060 R1");
    access(1, 0, 16'h00FF, 8'h22, 2'd0, 0, "n_00FF R1");
    access(0, 0, 16'h0100, 8'h00, 2'd0, 0, "n_0100 R1");
    access(0, 0, 16'h10FF, 8'h00, 2'd3, 0, "n_10FF R4");
    access(0, 0, 16'h1100, 8'h00, 2'd0, 0, "n_1100 R5");
    access(0, 0, 16'h8001, 8'h00, 2'd1, 0, "n_rd_w1 R7");
    access(1, 0, 16'hFFFF, 8'h5C, 2'd3, 0, "n_wr_w3 R6");
    access(1, 0, 16'h4321, 8'h77, 2'd2, 1, "n_disturb R9");
    access(0, 0, 16'h2468, 8'h00, 2'd0, 1, "n_disturb0 R10");
    // R3 short I/O path
    access(0, 1, 16'h0000, 8'h00, 2'd0, 0, "io_0 R3");
    access(1, 1, 16'h003F, 8'h33, 2'd0, 0, "io_63 R3");
    access(0, 1, 16'hFFE5, 8'h00, 2'd0, 0, "io_hi R3");
    // R2 compatible layout
    compatMode = 1'b1;
    access(0, 0, 16'h005F, 8'h00, 2'd0, 0, "c_005F R2");
    access(0, 0, 16'h0060, 8'h00, 2'd0, 0, "c_0060 R2");
    access(0, 0, 16'h00FF, 8'h00, 2'd0, 0, "c_00FF R2");
    access(1, 0, 16'h0FFF, 8'h44, 2'd0, 0, "c_0FFF R2");
    access(0, 0, 16'h1000, 8'h00, 2'd1, 0, "c_1000 R2");
    access(1, 0, 16'h10FF, 8'h66, 2'd2, 1, "c_10FF R9");
    // R8 external disabled
    extEnable = 1'b0;
    access(0, 0, 16'h1000, 8'h00, 2'd3, 0, "c_off R8");
    access(0, 0, 16'h0FFF, 8'h00, 2'd3, 0, "c_off_int R8");
    compatMode = 1'b0;
    access(1, 0, 16'hC000, 8'h99, 2'd2, 0, "n_off_wr R8");
    access(0, 0, 16'h1100, 8'h00, 2'd0, 0, "n_off_rd R8");
    access(0, 0, 16'h10FF, 8'h00, 2'd0, 0, "n_off_int R8");
    extEnable = 1'b1;
    access(0, 0, 16'h1100, 8'h00, 2'd2, 0, "n_back R5");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end
endmodule